// File: doc/BRIEF.md
# Operand Forwarding Unit

This block decides, for a five-stage in-order pipeline, where each ALU operand of the instruction in the execute stage should come from. It compares the two source register indices held in the decode-to-execute register against the destination indices of the two older instructions still in flight. Those two older instructions sit in the execute-to-memory register and in the memory-to-writeback register. The pipeline's operand multiplexers use the resulting selects to take the newest value of a register before it reaches the register file.

The unit also drives the same-cycle bypass at the two register file read ports in decode. A register that writeback stores in a given cycle is returned to a decode read of that register in the same cycle, as if the write completed before the read. The unit holds no state; every output is a combinational function of the current indices and write enables.

Index 0 is the hardwired zero register and never takes part in forwarding. The data memory read output has no path into execute. An instruction that consumes a load result one slot later must be held for a cycle by stall logic outside this block, and then picks the value up from the memory-to-writeback path.

Top module: `fwd_unit_top`

## Requirements
- R1: Operand A select is 2'b10 (execute-to-memory ALU result) when the memory-stage write enable is 1, the memory-stage destination index is nonzero, and the execute-stage source 1 index equals it.
- R2: Operand A select is 2'b01 (writeback value) when the writeback-stage write enable is 1, the writeback destination index is nonzero, execute-stage source 1 equals it, and the R1 condition is false.
- R3: When both older instructions write the register named by an execute-stage source, the select is 2'b10: the newer, memory-stage result wins.
- R4: Operand B select follows the rules of R1 to R3 using execute-stage source 2, independently of operand A.
- R5: A source index of 0 never forwards: the select stays 2'b00 (register file value) and the read-port bypass stays 0, even when an older instruction writes index 0 with its enable set.
- R6: A pipeline slot whose write enable is 0 never acts as a forwarding source, whatever its destination index.
- R7: The decode read-port bypass for port 1 (port 2) is 1 exactly when the writeback enable is 1, the writeback index is nonzero and equals the decode read index of port 1 (port 2).
- R8: With a load stalled one cycle ahead of its consumer (bubble in the memory stage, the load in writeback), the consumer's operand select is 2'b01. A load still in the memory stage yields 2'b10 only as an ALU-result select; there is no memory-data encoding.
- R9: The outputs follow input changes within the same cycle, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1_idx | input | IDX_W | Source 1 index of the instruction in execute |
| ex_rs2_idx | input | IDX_W | Source 2 index of the instruction in execute |
| mem_rd_idx | input | IDX_W | Destination index in the execute-to-memory register |
| mem_wr_en | input | 1 | Register write enable in the execute-to-memory register |
| wb_rd_idx | input | IDX_W | Destination index in the memory-to-writeback register (also the register file write index) |
| wb_wr_en | input | 1 | Register write enable in writeback (also the register file write enable) |
| id_rs1_idx | input | IDX_W | Register file read index of port 1 in decode |
| id_rs2_idx | input | IDX_W | Register file read index of port 2 in decode |
| opa_sel | output | 2 | Operand A source: 00 register, 10 memory stage, 01 writeback |
| opb_sel | output | 2 | Operand B source, same encoding |
| id_rs1_byp | output | 1 | Read port 1 returns the write data instead of the array |
| id_rs2_byp | output | 1 | Read port 2 returns the write data instead of the array |

## Verification
The checker evaluates the settled outputs whenever the inputs change. Each nonzero select must be justified by an enabled, nonzero, matching source in the right stage. A writeback select must not appear while the memory stage also matches. Index 0 must never forward, and each read-port bypass must agree with the write port. Only the bench's directed scenarios show the behaviour over a sequence: the load-then-stall hand-over from the memory path to the writeback path, operands A and B drawing from different stages at once, and outputs moving mid-cycle with no clock edge.

// File: rtl/fwd_pkg.sv
// Shared types for the operand forwarding unit.
// Assumes a two-bit select per ALU operand; the encoding is fixed because
// the operand multiplexers outside this block decode it.
package fwd_pkg;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,   // value read from the register file in decode
        SEL_WB  = 2'b01,   // final value being written back
        SEL_MEM = 2'b10    // ALU result held in the execute-to-memory register
    } opsel_e;

endpackage

// File: rtl/fwd_hit.sv
// Single-source match: reports that an older pipeline slot writes the
// register a consumer reads.
// Assumes index 0 is the hardwired zero register and is never a real result.
module fwd_hit #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] src_idx,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic             dst_we,
    output logic             hit
);

    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    // Match only when the slot really writes a nonzero register.
    always_comb begin
        hit = dst_we && (dst_idx != ZERO_IDX) && (src_idx == dst_idx);
    end

endmodule

// File: rtl/fwd_operand_sel.sv
// Select for one ALU operand: the memory-stage result beats the writeback
// value, and both beat the register file value.
// Assumes the memory-stage instruction is younger than the writeback one.
module fwd_operand_sel #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] src_idx,
    input  logic [IDX_W-1:0] mem_rd_idx,
    input  logic             mem_wr_en,
    input  logic [IDX_W-1:0] wb_rd_idx,
    input  logic             wb_wr_en,
    output logic [1:0]       sel
);
    import fwd_pkg::*;

    logic   mem_hit;
    logic   wb_hit;
    opsel_e sel_e;

    fwd_hit #(.IDX_W(IDX_W)) u_mem_hit (
        .src_idx (src_idx),
        .dst_idx (mem_rd_idx),
        .dst_we  (mem_wr_en),
        .hit     (mem_hit)
    );

    fwd_hit #(.IDX_W(IDX_W)) u_wb_hit (
        .src_idx (src_idx),
        .dst_idx (wb_rd_idx),
        .dst_we  (wb_wr_en),
        .hit     (wb_hit)
    );

    // Priority pick of the newest producer.
    always_comb begin
        if (mem_hit)      sel_e = SEL_MEM;
        else if (wb_hit)  sel_e = SEL_WB;
        else              sel_e = SEL_RF;
    end

    assign sel = sel_e;

endmodule

// File: rtl/rf_read_bypass.sv
// Write-before-read bypass for one register file read port: the value
// written this cycle is returned to a read of the same register.
// Assumes the write port is the writeback stage of the same pipeline.
module rf_read_bypass #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_en,
    output logic             byp
);

    fwd_hit #(.IDX_W(IDX_W)) u_hit (
        .src_idx (rd_idx),
        .dst_idx (wr_idx),
        .dst_we  (wr_en),
        .hit     (byp)
    );

endmodule

// File: rtl/fwd_unit_top.sv
// Operand forwarding unit: ALU operand selects for execute and the
// same-cycle bypass flags for the two decode read ports.
// Assumes load data never feeds execute directly; a load consumer is
// stalled elsewhere and then served from the writeback path.
module fwd_unit_top #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] ex_rs1_idx,
    input  logic [IDX_W-1:0] ex_rs2_idx,
    input  logic [IDX_W-1:0] mem_rd_idx,
    input  logic             mem_wr_en,
    input  logic [IDX_W-1:0] wb_rd_idx,
    input  logic             wb_wr_en,
    input  logic [IDX_W-1:0] id_rs1_idx,
    input  logic [IDX_W-1:0] id_rs2_idx,
    output logic [1:0]       opa_sel,
    output logic [1:0]       opb_sel,
    output logic             id_rs1_byp,
    output logic             id_rs2_byp
);

    localparam int NUM_SRC = 2;

    logic [IDX_W-1:0] ex_src [NUM_SRC];
    logic [IDX_W-1:0] id_src [NUM_SRC];
    logic [1:0]       sel_v  [NUM_SRC];
    logic             byp_v  [NUM_SRC];

    // Gather per-source indices into arrays for the replicated slices.
    always_comb begin
        ex_src[0] = ex_rs1_idx;
        ex_src[1] = ex_rs2_idx;
        id_src[0] = id_rs1_idx;
        id_src[1] = id_rs2_idx;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        fwd_operand_sel #(.IDX_W(IDX_W)) u_opsel (
            .src_idx    (ex_src[g]),
            .mem_rd_idx (mem_rd_idx),
            .mem_wr_en  (mem_wr_en),
            .wb_rd_idx  (wb_rd_idx),
            .wb_wr_en   (wb_wr_en),
            .sel        (sel_v[g])
        );

        rf_read_bypass #(.IDX_W(IDX_W)) u_rfbyp (
            .rd_idx (id_src[g]),
            .wr_idx (wb_rd_idx),
            .wr_en  (wb_wr_en),
            .byp    (byp_v[g])
        );
    end

    // Drive the named outputs from the per-source results.
    always_comb begin
        opa_sel    = sel_v[0];
        opb_sel    = sel_v[1];
        id_rs1_byp = byp_v[0];
        id_rs2_byp = byp_v[1];
    end

endmodule

// File: rtl/fwd_unit_chk.sv
// Checker for the forwarding unit: settled-output rules evaluated whenever
// an input changes. Checks are skipped while any input is still unknown.
module fwd_unit_chk #(
    parameter int IDX_W = 5
) (
    input logic [IDX_W-1:0] ex_rs1_idx,
    input logic [IDX_W-1:0] ex_rs2_idx,
    input logic [IDX_W-1:0] mem_rd_idx,
    input logic             mem_wr_en,
    input logic [IDX_W-1:0] wb_rd_idx,
    input logic             wb_wr_en,
    input logic [IDX_W-1:0] id_rs1_idx,
    input logic [IDX_W-1:0] id_rs2_idx,
    input logic [1:0]       opa_sel,
    input logic [1:0]       opb_sel,
    input logic             id_rs1_byp,
    input logic             id_rs2_byp
);

    logic known;

    // Inputs must be defined before any rule is judged.
    always_comb begin
        known = !$isunknown({ex_rs1_idx, ex_rs2_idx, mem_rd_idx, mem_wr_en,
                             wb_rd_idx, wb_wr_en, id_rs1_idx, id_rs2_idx});
    end

    // Rule checks on the settled outputs.
    always_comb begin
        if (known) begin
            // R1
            opa_mem_src_chk: assert (opa_sel != 2'b10 ||
                (mem_wr_en && mem_rd_idx != '0 && ex_rs1_idx == mem_rd_idx))
                else $error("opa_sel=10 without a memory-stage producer");
            // R2
            opa_wb_src_chk: assert (opa_sel != 2'b01 ||
                (wb_wr_en && wb_rd_idx != '0 && ex_rs1_idx == wb_rd_idx))
                else $error("opa_sel=01 without a writeback producer");
            // R3
            opa_newest_chk: assert (!(opa_sel == 2'b01 && mem_wr_en &&
                mem_rd_idx != '0 && ex_rs1_idx == mem_rd_idx))
                else $error("opa_sel took writeback over a matching memory stage");
            // R4
            opb_mem_src_chk: assert (opb_sel != 2'b10 ||
                (mem_wr_en && mem_rd_idx != '0 && ex_rs2_idx == mem_rd_idx))
                else $error("opb_sel=10 without a memory-stage producer");
            // R4
            opb_wb_src_chk: assert (opb_sel != 2'b01 ||
                (wb_wr_en && wb_rd_idx != '0 && ex_rs2_idx == wb_rd_idx &&
                 !(mem_wr_en && mem_rd_idx != '0 && ex_rs2_idx == mem_rd_idx)))
                else $error("opb_sel=01 without a valid writeback producer");
            // R5
            zero_src_chk: assert ((ex_rs1_idx != '0 || opa_sel == 2'b00) &&
                (ex_rs2_idx != '0 || opb_sel == 2'b00))
                else $error("index 0 forwarded to an operand");
            // R7
            rd1_byp_chk: assert (id_rs1_byp ==
                (wb_wr_en && wb_rd_idx != '0 && id_rs1_idx == wb_rd_idx))
                else $error("read port 1 bypass disagrees with write port");
            // R7
            rd2_byp_chk: assert (id_rs2_byp ==
                (wb_wr_en && wb_rd_idx != '0 && id_rs2_idx == wb_rd_idx))
                else $error("read port 2 bypass disagrees with write port");
        end
    end

endmodule

bind fwd_unit_top fwd_unit_chk #(.IDX_W(IDX_W)) u_chk (
    .ex_rs1_idx (ex_rs1_idx),
    .ex_rs2_idx (ex_rs2_idx),
    .mem_rd_idx (mem_rd_idx),
    .mem_wr_en  (mem_wr_en),
    .wb_rd_idx  (wb_rd_idx),
    .wb_wr_en   (wb_wr_en),
    .id_rs1_idx (id_rs1_idx),
    .id_rs2_idx (id_rs2_idx),
    .opa_sel    (opa_sel),
    .opb_sel    (opb_sel),
    .id_rs1_byp (id_rs1_byp),
    .id_rs2_byp (id_rs2_byp)
);

// File: tb/sim_fwd_unit_top.sv
// Directed bench for the forwarding unit; one task per scenario.
module sim_fwd_unit_top;

    localparam int IDX_W = 5;

    logic             clk;
    logic [IDX_W-1:0] ex_rs1_idx, ex_rs2_idx, mem_rd_idx, wb_rd_idx;
    logic [IDX_W-1:0] id_rs1_idx, id_rs2_idx;
    logic             mem_wr_en, wb_wr_en;
    logic [1:0]       opa_sel, opb_sel;
    logic             id_rs1_byp, id_rs2_byp;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    fwd_unit_top #(.IDX_W(IDX_W)) u0 (
        .ex_rs1_idx (ex_rs1_idx),
        .ex_rs2_idx (ex_rs2_idx),
        .mem_rd_idx (mem_rd_idx),
        .mem_wr_en  (mem_wr_en),
        .wb_rd_idx  (wb_rd_idx),
        .wb_wr_en   (wb_wr_en),
        .id_rs1_idx (id_rs1_idx),
        .id_rs2_idx (id_rs2_idx),
        .opa_sel    (opa_sel),
        .opb_sel    (opb_sel),
        .id_rs1_byp (id_rs1_byp),
        .id_rs2_byp (id_rs2_byp)
    );

    // 200 MHz clock paces the scenarios.
    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input int rs1, input int rs2, input int mrd,
                         input bit mwe, input int wrd, input bit wwe,
                         input int ir1, input int ir2);
        @(negedge clk);
        ex_rs1_idx = IDX_W'(rs1);
        ex_rs2_idx = IDX_W'(rs2);
        mem_rd_idx = IDX_W'(mrd);
        mem_wr_en  = mwe;
        wb_rd_idx  = IDX_W'(wrd);
        wb_wr_en   = wwe;
        id_rs1_idx = IDX_W'(ir1);
        id_rs2_idx = IDX_W'(ir2);
        #1;
    endtask

    task automatic t_idle();
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R5", "idle opa", int'(opa_sel), 0);
        chk("R5", "idle opb", int'(opb_sel), 0);
        chk("R7", "idle byp1", int'(id_rs1_byp), 0);
        chk("R7", "idle byp2", int'(id_rs2_byp), 0);
    endtask

    task automatic t_mem_fwd();
        drive(3, 4, 3, 1, 0, 0, 0, 0);
        chk("R1", "mem hit opa", int'(opa_sel), 2);
        chk("R4", "no hit opb", int'(opb_sel), 0);
        drive(31, 30, 31, 1, 0, 0, 0, 0);
        chk("R1", "max index opa", int'(opa_sel), 2);
        chk("R4", "max index opb", int'(opb_sel), 0);
    endtask

    task automatic t_wb_fwd();
        drive(8, 7, 2, 1, 7, 1, 0, 0);
        chk("R2", "wb hit opb", int'(opb_sel), 1);
        chk("R2", "no hit opa", int'(opa_sel), 0);
        drive(9, 1, 9, 0, 9, 1, 0, 0);
        chk("R2", "mem disabled, wb wins opa", int'(opa_sel), 1);
    endtask

    task automatic t_priority();
        drive(5, 5, 5, 1, 5, 1, 0, 0);
        chk("R3", "both match opa", int'(opa_sel), 2);
        chk("R3", "both match opb", int'(opb_sel), 2);
    endtask

    task automatic t_independent();
        drive(11, 14, 11, 1, 14, 1, 0, 0);
        chk("R4", "opa from mem", int'(opa_sel), 2);
        chk("R4", "opb from wb", int'(opb_sel), 1);
    endtask

    task automatic t_zero();
        drive(0, 0, 0, 1, 0, 1, 0, 0);
        chk("R5", "x0 opa", int'(opa_sel), 0);
        chk("R5", "x0 opb", int'(opb_sel), 0);
        chk("R5", "x0 byp1", int'(id_rs1_byp), 0);
        chk("R5", "x0 byp2", int'(id_rs2_byp), 0);
    endtask

    task automatic t_disabled();
        drive(9, 10, 9, 0, 10, 0, 10, 9);
        chk("R6", "mem we=0 opa", int'(opa_sel), 0);
        chk("R6", "wb we=0 opb", int'(opb_sel), 0);
        chk("R6", "wb we=0 byp1", int'(id_rs1_byp), 0);
    endtask

    task automatic t_rf_bypass();
        drive(0, 0, 0, 0, 12, 1, 12, 13);
        chk("R7", "byp1 match", int'(id_rs1_byp), 1);
        chk("R7", "byp2 differ", int'(id_rs2_byp), 0);
        drive(0, 0, 0, 0, 12, 1, 12, 12);
        chk("R7", "both ports byp1", int'(id_rs1_byp), 1);
        chk("R7", "both ports byp2", int'(id_rs2_byp), 1);
    endtask

    task automatic t_load_use();
        // Load to x6 in memory stage, consumer reads x6 in decode.
        drive(2, 0, 6, 1, 0, 0, 6, 0);
        chk("R8", "consumer in decode, no byp", int'(id_rs1_byp), 0);
        // Stall: bubble in memory stage, load in writeback, consumer in execute.
        drive(6, 0, 0, 0, 6, 1, 0, 0);
        chk("R8", "consumer after stall", int'(opa_sel), 1);
    endtask

    task automatic t_comb();
        @(posedge clk);
        #0.5;
        ex_rs2_idx = 5'd20; mem_rd_idx = 5'd20; mem_wr_en = 1'b1;
        wb_wr_en = 1'b0; #0.5;
        chk("R9", "mid-cycle opb", int'(opb_sel), 2);
        mem_wr_en = 1'b0; #0.5;
        chk("R9", "mid-cycle opb drop", int'(opb_sel), 0);
    endtask

    initial begin
        t_idle();
        t_mem_fwd();
        t_wb_fwd();
        t_priority();
        t_independent();
        t_zero();
        t_disabled();
        t_rf_bypass();
        t_load_use();
        t_comb();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule